// File: doc/BRIEF.md
# Multi-Queue Ring Buffer Manager

This block manages a set of word-wide hardware queues that all live in one shared block of on-chip storage. Each queue is a circular buffer placed by a base pointer and sized by a two-bit code. Software, or any bus agent, pushes a word by writing the queue's access address and pops a word by reading it. Each queue has its own configuration word. Reading that word back also shows the queue's write and read pointers, so the fill level can be computed from a single read.

A pop from an empty queue returns zero. A push to a full queue is dropped. For the lower group of queues, both events leave a sticky flag in a status word, and software clears a flag by writing the word back with that bit at zero. Four level flags per queue (empty, nearly empty, nearly full, full) are driven out as registered vectors for neighbouring blocks to use. Interrupt generation is not part of this block.

The bus is word-addressed, with bits [9:8] selecting the region: 0x000+q is the configuration of queue q, 0x100+q is the access address of queue q, and 0x200+w is status word w. Any address with a bit set above bit 9 is ignored. Read data appears one cycle after the request, together with `bus_rvalid`.

Top module: `ringq_manager`

## Requirements
- R1: After reset every configuration word and status word reads 0x00000000, `bus_rvalid` is low, `q_empty` and `q_nempty` are all ones, and `q_full` and `q_nfull` are all zeros.
- R2: The configuration word layout is: bits 6:0 write pointer, 13:7 read pointer, 16:14 nearly-empty code, 19:17 nearly-full code, 21:20 size code, 23:22 entry-size code, 30:24 base in 16-word units, and bit 31 reads 0. Writing the word stores bits 30:14 exactly as written, clears both pointers and so empties the queue.
- R3: A read of an access address returns the oldest word pushed to that queue (first in, first out). Every read request gives `bus_rvalid` high with its data exactly one cycle later. A write request never raises `bus_rvalid`.
- R4: Each push or pop advances its pointer by one. The fill level equals (cfg - (cfg >> 7)) & 0x7F, so a full 128-word queue reports 0.
- R5: The storage index wraps modulo the buffer size, and data stays in order across the wrap.
- R6: A pop from an empty queue returns 0x00000000. For queues 0-31 it also sets that queue's underflow flag.
- R7: A push to a full queue is discarded and leaves the stored data unchanged. For queues 0-31 it also sets that queue's overflow flag.
- R8: Status word 0 (0x200) holds queues 0-15 and word 1 (0x201) holds queues 16-31. Queue q uses bit 2*(q%16) for underflow and bit 2*(q%16)+1 for overflow. A write keeps each flag whose written bit is 1 and clears each flag whose written bit is 0. A flag is set only by an underflow or overflow event.
- R9: Queues 32 and above never set a status flag, but still return zero when popped empty and still drop pushes when full.
- R10: Size codes 0, 1, 2 and 3 give capacities of 16, 32, 64 and 128 words.
- R11: Queue storage starts at word base*16, so queues with different bases hold independent data.
- R12: `q_nempty[q]` is high when the fill level is at or below the nearly-empty threshold. Codes 0 to 7 map to thresholds 0, 1, 2, 4, 8, 16, 32 and 64.
- R13: `q_nfull[q]` is high when the free space (capacity minus fill level) is at or below the nearly-full threshold, which uses the same code mapping as R12.
- R14: `q_empty[q]` is high when the fill level is 0, `q_full[q]` is high when the fill level equals the capacity, and the two are never high together. All four flag vectors follow a pointer change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (12) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| q_empty | output | NUM_Q (64) | Per-queue empty flag |
| q_nempty | output | NUM_Q (64) | Per-queue nearly-empty flag |
| q_nfull | output | NUM_Q (64) | Per-queue nearly-full flag |
| q_full | output | NUM_Q (64) | Per-queue full flag |

## Verification
The hardest state to reach is a 128-word queue that is completely full. Its pointer difference aliases to zero in the visible 7-bit fields, and a further push must still be seen as an overflow. The stimulus drives 128 pushes through the access address to reach it, then checks the readback count of 0, the full flag, the overflow bit, and that the first word popped is still the first word pushed. A second hard case is the buffer-index wrap. To reach it, the bench first moves the pointers of a 16-word queue away from zero, then fills the queue so the stored words straddle the end of the buffer and drains it in order.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

  // configuration word field positions
  localparam int CFG_WPTR_LSB = 0;
  localparam int CFG_RPTR_LSB = 7;
  localparam int CFG_FIELD_LSB = 14;
  localparam int CFG_FIELD_W = 17;
  localparam int BASE_W = 7;
  localparam int PTR_W = 8;
  localparam int SLOT_W = 4;   // base granule is 16 words

  typedef enum logic [1:0] {
    REG_CFG = 2'd0,
    REG_ACC = 2'd1,
    REG_STS = 2'd2,
    REG_NONE = 2'd3
  } region_e;

  // stored configuration fields, packed in word order 30:14
  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [1:0]        esize;
    logic [1:0]        bsize;
    logic [2:0]        nf_code;
    logic [2:0]        ne_code;
  } qcfg_t;

  // capacity in words from the size code
  function automatic logic [PTR_W-1:0] span_of(input logic [1:0] code);
    return PTR_W'(16) << code;
  endfunction

  // watermark threshold from its 3-bit code
  function automatic logic [PTR_W-1:0] mark_of(input logic [2:0] code);
    if (code == 3'd0) return '0;
    return PTR_W'(1) << (code - 3'd1);
  endfunction

endpackage

// File: rtl/ringq_store.sv
module ringq_store #(
  parameter int DEPTH = 2048,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // single-port, synchronous read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/ringq_slot.sv
module ringq_slot
  import ringq_pkg::*;
#(
  parameter int SRAM_AW = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  qcfg_t              cfg_new,
  input  logic               push,
  input  logic               pop,
  output logic [31:0]        cfg_rd,
  output logic [SRAM_AW-1:0] wr_addr,
  output logic [SRAM_AW-1:0] rd_addr,
  output logic               is_empty,
  output logic               is_full,
  output logic               fl_empty,
  output logic               fl_nempty,
  output logic               fl_nfull,
  output logic               fl_full
);

  localparam int FULL_AW = BASE_W + SLOT_W;

  qcfg_t             cfg_q;
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [PTR_W-1:0]  span, level, free_cnt, idx_mask;
  logic [FULL_AW-1:0] base_word, wa_full, ra_full;

  // pointers run free over 8 bits; capacity <= 128 divides 256, so the
  // difference is the exact level and the low bits index the buffer
  always_comb begin
    span      = span_of(cfg_q.bsize);
    idx_mask  = span - PTR_W'(1);
    level     = wp_q - rp_q;
    free_cnt  = span - level;
    is_empty  = (level == '0);
    is_full   = (level == span);
    base_word = {cfg_q.base, {SLOT_W{1'b0}}};
    wa_full   = base_word + FULL_AW'(wp_q & idx_mask);
    ra_full   = base_word + FULL_AW'(rp_q & idx_mask);
  end

  assign wr_addr = SRAM_AW'(wa_full);
  assign rd_addr = SRAM_AW'(ra_full);
  assign cfg_rd  = {1'b0, cfg_q, rp_q[6:0], wp_q[6:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_new;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      if (push) wp_q <= wp_q + PTR_W'(1);
      if (pop)  rp_q <= rp_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_empty  <= 1'b1;
      fl_nempty <= 1'b1;
      fl_nfull  <= 1'b0;
      fl_full   <= 1'b0;
    end else begin
      fl_empty  <= is_empty;
      fl_nempty <= (level <= mark_of(cfg_q.ne_code));
      fl_nfull  <= (free_cnt <= mark_of(cfg_q.nf_code));
      fl_full   <= is_full;
    end
  end

endmodule

// File: rtl/ringq_sticky.sv
module ringq_sticky #(
  parameter int FLAG_Q = 32,
  localparam int NW = FLAG_Q / 16,
  localparam int WI_W = (NW > 1) ? $clog2(NW) : 1,
  localparam int SQ_W = $clog2(FLAG_Q)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SQ_W-1:0]   set_q,
  input  logic              set_uf,
  input  logic              set_of,
  input  logic              clr_we,
  input  logic [WI_W-1:0]   clr_word,
  input  logic [31:0]       clr_data,
  output logic [NW*32-1:0]  flags
);

  // two bits per queue: even = underflow, odd = overflow
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      if (clr_we)
        flags[int'(clr_word)*32 +: 32] <= flags[int'(clr_word)*32 +: 32] & clr_data;
      if (set_uf) flags[{set_q, 1'b0}] <= 1'b1;
      if (set_of) flags[{set_q, 1'b1}] <= 1'b1;
    end
  end

endmodule

// File: rtl/ringq_manager.sv
module ringq_manager
  import ringq_pkg::*;
#(
  parameter int NUM_Q = 64,
  parameter int FLAG_Q = 32,
  parameter int SRAM_WORDS = 2048,
  parameter int BUS_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_nempty,
  output logic [NUM_Q-1:0]  q_nfull,
  output logic [NUM_Q-1:0]  q_full
);

  localparam int SRAM_AW = $clog2(SRAM_WORDS);
  localparam int QW = $clog2(NUM_Q);
  localparam int NW = FLAG_Q / 16;
  localparam int WI_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int SQ_W = $clog2(FLAG_Q);

  // ---------------- address decode ----------------
  logic [7:0]    idx;
  region_e       region;
  logic          in_space, q_ok, low_q;
  logic [QW-1:0] q;
  logic          cfg_hit, acc_hit, sts_hit;
  logic          sel_empty, sel_full;
  logic          push_go, pop_go, miss_rd, miss_wr;
  qcfg_t         cfg_new;

  assign idx      = bus_addr[7:0];
  assign region   = region_e'(bus_addr[9:8]);
  assign in_space = ((bus_addr >> 10) == '0);
  assign q        = idx[QW-1:0];
  assign q_ok     = int'(idx) < NUM_Q;
  assign low_q    = int'(idx) < FLAG_Q;
  assign cfg_hit  = bus_req && in_space && (region == REG_CFG) && q_ok;
  assign acc_hit  = bus_req && in_space && (region == REG_ACC) && q_ok;
  assign sts_hit  = bus_req && in_space && (region == REG_STS) && (int'(idx) < NW);
  assign cfg_new  = qcfg_t'(bus_wdata[CFG_FIELD_LSB +: CFG_FIELD_W]);

  // ---------------- per-queue state ----------------
  logic [31:0]        slot_cfg [NUM_Q];
  logic [SRAM_AW-1:0] slot_wa  [NUM_Q];
  logic [SRAM_AW-1:0] slot_ra  [NUM_Q];
  logic [NUM_Q-1:0]   slot_empty, slot_full;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
    logic hit_g;
    assign hit_g = (q == QW'(g));
    ringq_slot #(.SRAM_AW(SRAM_AW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_hit && bus_we && hit_g),
      .cfg_new  (cfg_new),
      .push     (push_go && hit_g),
      .pop      (pop_go && hit_g),
      .cfg_rd   (slot_cfg[g]),
      .wr_addr  (slot_wa[g]),
      .rd_addr  (slot_ra[g]),
      .is_empty (slot_empty[g]),
      .is_full  (slot_full[g]),
      .fl_empty (q_empty[g]),
      .fl_nempty(q_nempty[g]),
      .fl_nfull (q_nfull[g]),
      .fl_full  (q_full[g])
    );
  end

  assign sel_empty = slot_empty[q];
  assign sel_full  = slot_full[q];
  assign push_go   = acc_hit && bus_we && !sel_full;
  assign pop_go    = acc_hit && !bus_we && !sel_empty;
  assign miss_wr   = acc_hit && bus_we && sel_full;
  assign miss_rd   = acc_hit && !bus_we && sel_empty;

  // ---------------- shared storage ----------------
  logic [31:0] mem_rdata;

  ringq_store #(.DEPTH(SRAM_WORDS), .DW(32)) u_store (
    .clk  (clk),
    .en   (push_go || pop_go),
    .we   (push_go),
    .addr (push_go ? slot_wa[q] : slot_ra[q]),
    .wdata(bus_wdata),
    .rdata(mem_rdata)
  );

  // ---------------- sticky event flags ----------------
  logic [NW*32-1:0] sts_vec;

  ringq_sticky #(.FLAG_Q(FLAG_Q)) u_sticky (
    .clk     (clk),
    .rst     (rst),
    .set_q   (idx[SQ_W-1:0]),
    .set_uf  (miss_rd && low_q),
    .set_of  (miss_wr && low_q),
    .clr_we  (sts_hit && bus_we),
    .clr_word(idx[WI_W-1:0]),
    .clr_data(bus_wdata),
    .flags   (sts_vec)
  );

  // ---------------- read return ----------------
  logic        from_mem;
  logic [31:0] rd_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      from_mem   <= 1'b0;
      rd_hold    <= '0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      from_mem   <= pop_go;
      rd_hold    <= '0;
      if (cfg_hit && !bus_we)
        rd_hold <= slot_cfg[q];
      else if (sts_hit && !bus_we)
        rd_hold <= sts_vec[int'(idx[WI_W-1:0])*32 +: 32];
    end
  end

  // pops take data from the storage output register, all else from rd_hold
  assign bus_rdata = from_mem ? mem_rdata : rd_hold;

endmodule

// File: rtl/ringq_manager_chk.sv
module ringq_manager_chk #(
  parameter int NUM_Q = 64,
  parameter int FLAG_Q = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_req,
  input logic                  bus_we,
  input logic                  bus_rvalid,
  input logic [31:0]           bus_rdata,
  input logic [NUM_Q-1:0]      q_empty,
  input logic [NUM_Q-1:0]      q_nempty,
  input logic [NUM_Q-1:0]      q_nfull,
  input logic [NUM_Q-1:0]      q_full,
  input logic                  miss_rd,
  input logic                  miss_wr,
  input logic [FLAG_Q*2-1:0]   sticky
);

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  assert_no_stray_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    miss_rd |=> (bus_rdata == 32'h0));

  assert_flag_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (|(sticky & ~$past(sticky))) |-> $past(miss_rd || miss_wr));

  assert_empty_full_excl_R14: assert property (@(posedge clk) disable iff (rst)
    (q_empty & q_full) == '0);

  assert_empty_implies_ne_R12: assert property (@(posedge clk) disable iff (rst)
    (q_empty & ~q_nempty) == '0);

  assert_full_implies_nf_R13: assert property (@(posedge clk) disable iff (rst)
    (q_full & ~q_nfull) == '0);

endmodule

bind ringq_manager ringq_manager_chk #(.NUM_Q(NUM_Q), .FLAG_Q(FLAG_Q)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_rvalid(bus_rvalid),
  .bus_rdata (bus_rdata),
  .q_empty   (q_empty),
  .q_nempty  (q_nempty),
  .q_nfull   (q_nfull),
  .q_full    (q_full),
  .miss_rd   (miss_rd),
  .miss_wr   (miss_wr),
  .sticky    (sts_vec)
);

// File: tb/sim_ringq_manager.sv
module sim_ringq_manager;

  localparam int CLK_PERIOD = 10;
  localparam int NQ = 64;
  localparam logic [11:0] CFG = 12'h000;
  localparam logic [11:0] ACC = 12'h100;
  localparam logic [11:0] STS = 12'h200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NQ-1:0] q_empty, q_nempty, q_nfull, q_full;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ringq_manager u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .q_empty(q_empty), .q_nempty(q_nempty), .q_nfull(q_nfull), .q_full(q_full)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int base, input int esz, input int bsz,
                                     input int nf, input int ne);
    return {1'b0, 7'(base), 2'(esz), 2'(bsz), 3'(nf), 3'(ne), 14'd0};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
    chk("R3 rvalid", 64'(bus_rvalid), 64'd1);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rvalid idle", 64'(bus_rvalid), 64'd0);
    chk("R1 empty", 64'(q_empty), {64{1'b1}});
    chk("R1 nempty", 64'(q_nempty), {64{1'b1}});
    chk("R1 full", 64'(q_full), 64'd0);
    chk("R1 nfull", 64'(q_nfull), 64'd0);
    rd(CFG + 12'd0, d);  chk("R1 cfg q0", 64'(d), 64'd0);
    rd(CFG + 12'd63, d); chk("R1 cfg q63", 64'(d), 64'd0);
    rd(STS, d);          chk("R1 sts0", 64'(d), 64'd0);
    rd(STS + 12'd1, d);  chk("R1 sts1", 64'(d), 64'd0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(CFG + 12'd3, mk(4, 1, 0, 2, 3));
    rd(CFG + 12'd3, d);
    chk("R2 cfg readback", 64'(d), 64'(mk(4, 1, 0, 2, 3)));
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    for (int i = 1; i <= 5; i++) wr(ACC + 12'd3, 32'hA000_0000 + i);
    rd(CFG + 12'd3, d);
    chk("R4 ptr fields", 64'(d), 64'(mk(4, 1, 0, 2, 3) | 32'd5));
    chk("R4 level formula", 64'((d - (d >> 7)) & 32'h7F), 64'd5);
    for (int i = 1; i <= 5; i++) begin
      rd(ACC + 12'd3, d);
      chk("R3 fifo order", 64'(d), 64'(32'hA000_0000 + i));
    end
    rd(CFG + 12'd3, d);
    chk("R4 ptrs after pop", 64'(d), 64'(mk(4, 1, 0, 2, 3) | (32'd5 << 7) | 32'd5));
  endtask

  task automatic t_wrap_overflow();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) wr(ACC + 12'd3, 32'hB000_0000 + i);
    settle();
    chk("R10 full at 16", 64'(q_full[3]), 64'd1);
    chk("R14 not empty", 64'(q_empty[3]), 64'd0);
    rd(CFG + 12'd3, d);
    chk("R4 level 16", 64'((d - (d >> 7)) & 32'h7F), 64'd16);
    wr(ACC + 12'd3, 32'hDEAD_BEEF);
    rd(STS, d);
    chk("R7 overflow bit", 64'(d), 64'h80);
    wr(STS, 32'hFFFF_FFFF);
    rd(STS, d);
    chk("R8 write 1 keeps", 64'(d), 64'h80);
    wr(STS, 32'hFFFF_FF7F);
    rd(STS, d);
    chk("R8 write 0 clears", 64'(d), 64'h0);
    for (int i = 0; i < 16; i++) begin
      rd(ACC + 12'd3, d);
      chk("R5 R7 wrap order", 64'(d), 64'(32'hB000_0000 + i));
    end
    rd(ACC + 12'd3, d);
    chk("R6 empty pop zero", 64'(d), 64'd0);
    rd(STS, d);
    chk("R6 underflow bit", 64'(d), 64'h40);
    wr(STS, 32'h0);
    rd(STS, d);
    chk("R8 cleared", 64'(d), 64'h0);
    settle();
    chk("R14 empty again", 64'(q_empty[3]), 64'd1);
  endtask

  task automatic t_thresh();
    wr(CFG + 12'd6, mk(6, 0, 0, 2, 3));
    for (int i = 0; i < 4; i++) wr(ACC + 12'd6, 32'h6000_0000 + i);
    settle();
    chk("R12 ne at 4", 64'(q_nempty[6]), 64'd1);
    wr(ACC + 12'd6, 32'h6000_0004);
    settle();
    chk("R12 ne at 5", 64'(q_nempty[6]), 64'd0);
    for (int i = 5; i < 13; i++) wr(ACC + 12'd6, 32'h6000_0000 + i);
    settle();
    chk("R13 nf free 3", 64'(q_nfull[6]), 64'd0);
    wr(ACC + 12'd6, 32'h6000_000D);
    settle();
    chk("R13 nf free 2", 64'(q_nfull[6]), 64'd1);
    chk("R14 not full", 64'(q_full[6]), 64'd0);
  endtask

  task automatic t_base();
    logic [31:0] d;
    wr(CFG + 12'd5, mk(5, 0, 0, 0, 0));
    wr(ACC + 12'd5, 32'h5555_0001);
    wr(ACC + 12'd5, 32'h5555_0002);
    rd(ACC + 12'd6, d);
    chk("R11 q6 intact", 64'(d), 64'h6000_0000);
    rd(ACC + 12'd5, d);
    chk("R11 q5 own data", 64'(d), 64'h5555_0001);
  endtask

  task automatic t_big();
    logic [31:0] d;
    wr(CFG + 12'd1, mk(8, 0, 3, 0, 0));
    for (int i = 0; i < 127; i++) wr(ACC + 12'd1, 32'h1000_0000 + i);
    settle();
    chk("R10 128 not full", 64'(q_full[1]), 64'd0);
    wr(ACC + 12'd1, 32'h1000_007F);
    settle();
    chk("R10 128 full", 64'(q_full[1]), 64'd1);
    rd(CFG + 12'd1, d);
    chk("R4 full 128 reads 0", 64'((d - (d >> 7)) & 32'h7F), 64'd0);
    wr(ACC + 12'd1, 32'hFFFF_0000);
    rd(STS, d);
    chk("R7 q1 overflow", 64'(d), 64'h08);
    wr(STS, 32'h0);
    rd(ACC + 12'd1, d);
    chk("R7 R11 first kept", 64'(d), 64'h1000_0000);
  endtask

  task automatic t_high();
    logic [31:0] d;
    wr(CFG + 12'd40, mk(16, 0, 0, 0, 0));
    rd(ACC + 12'd40, d);
    chk("R9 high empty zero", 64'(d), 64'd0);
    for (int i = 0; i < 17; i++) wr(ACC + 12'd40, 32'h4000_0000 + i);
    rd(STS, d);        chk("R9 sts0 clean", 64'(d), 64'd0);
    rd(STS + 12'd1, d); chk("R9 sts1 clean", 64'(d), 64'd0);
    settle();
    chk("R9 high full", 64'(q_full[40]), 64'd1);
    rd(ACC + 12'd40, d);
    chk("R9 high first", 64'(d), 64'h4000_0000);
    rd(ACC + 12'd20, d);
    chk("R6 q20 zero", 64'(d), 64'd0);
    rd(STS + 12'd1, d);
    chk("R8 q20 in word1", 64'(d), 64'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_fifo();
    t_wrap_overflow();
    t_thresh();
    t_base();
    t_big();
    t_high();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule